// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional jump or a counted loop goes to its target. Each cycle in which `in_valid` is high, it takes a 5-bit condition selector, the five status flags and a 16-bit count value. The flags are carry, zero, sign, overflow and parity. The decision is registered and appears on the outputs one clock later.

It handles several kinds of condition:
- single-flag tests;
- unsigned comparisons built from carry and zero;
- signed comparisons built from sign, overflow and zero;
- a jump taken when the count is zero;
- three counted loops.

A counted loop returns the decremented count together with a write enable, so the surrounding core can update its count register. No flag is changed by the decrement. Target address computation and instruction fetch belong to other blocks.

The selector codes come in complementary pairs where that applies. An alias such as "below" or "equal" uses the same code as the flag test it stands for.

Top module: `branch_cond_eval`

## Requirements
- R1: While reset is asserted and after it is released with no valid request, `taken`, `cnt_wr`, `out_valid` and `cnt_out` are all zero.
- R2: Single-flag selectors are taken as follows, with no count write:
  - 0 when CF=1 (also "below"), 1 when CF=0 (also "above-or-equal");
  - 2 when ZF=1 (also "equal"), 3 when ZF=0;
  - 6 when SF=1, 7 when SF=0;
  - 8 when PF=1, 9 when PF=0;
  - 14 when OF=1, 15 when OF=0.
- R3: Unsigned selectors: 4 (below-or-equal) is taken when CF=1 or ZF=1, and 5 (above) is taken when CF=0 and ZF=0.
- R4: Signed selectors:
  - 10 (less) is taken when SF differs from OF, and 11 (greater-or-equal) when they match;
  - 12 (less-or-equal) is taken when ZF=1 or SF differs from OF, and 13 (greater) is its complement.
- R5: Selector 16 is taken exactly when the count is zero. It never asserts `cnt_wr`, and `cnt_out` equals the input count.
- R6: Selector 17 (loop) asserts `cnt_wr` with `cnt_out` equal to the count minus one, modulo 2^16. It is taken when that new count is nonzero, so a count of 0 wraps to 0xFFFF and is taken.
- R7: Selector 18 (loop while zero) writes the decremented count as in R6. It is taken only when the new count is nonzero and ZF=1.
- R8: Selector 19 (loop while nonzero) writes the decremented count as in R6. It is taken only when the new count is nonzero and ZF=0.
- R9: Selectors 20 to 31 are never taken, never write, and pass the input count to `cnt_out`.
- R10: A cycle with `in_valid` low gives `taken`, `cnt_wr` and `out_valid` low on the next cycle, whatever the other inputs are.
- R11: Results for inputs sampled at one clock edge appear on the outputs right after that edge. Back-to-back requests each get their own result with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid this cycle |
| cond_sel | input | 5 | Condition selector code |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_s | input | 1 | Sign flag |
| flag_o | input | 1 | Overflow flag |
| flag_p | input | 1 | Parity flag |
| count_in | input | 16 | Current count register value |
| out_valid | output | 1 | Registered result valid |
| taken | output | 1 | Branch or loop taken |
| cnt_wr | output | 1 | Write enable for the count register |
| cnt_out | output | 16 | Count value to write back |

## Verification
Every single-flag selector is driven with its flag both set and clear, which shows that each code looks at its own flag and has the right polarity. The unsigned and signed selectors get flag mixes where carry alone, zero alone, or only sign-versus-overflow decides the result. These mixes tell the compound conditions apart from their single-flag parts. The count selectors are tried with counts of 0, 1 and 3, which separates wrap-around, the loop exit, and the zero-flag qualifier. Reserved codes carry all flags set to catch any stray decode, and back-to-back requests confirm the one-cycle latency.

// File: rtl/bce_pkg.sv
package bce_pkg;
    localparam int SEL_W = 5;

    typedef struct packed {
        logic c;
        logic z;
        logic s;
        logic o;
        logic p;
    } flags_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_CSET  = 5'd0,
        SEL_CCLR  = 5'd1,
        SEL_ZSET  = 5'd2,
        SEL_ZCLR  = 5'd3,
        SEL_BE    = 5'd4,
        SEL_A     = 5'd5,
        SEL_SSET  = 5'd6,
        SEL_SCLR  = 5'd7,
        SEL_PSET  = 5'd8,
        SEL_PCLR  = 5'd9,
        SEL_LT    = 5'd10,
        SEL_GE    = 5'd11,
        SEL_LE    = 5'd12,
        SEL_GT    = 5'd13,
        SEL_OSET  = 5'd14,
        SEL_OCLR  = 5'd15,
        SEL_CNTZ  = 5'd16,
        SEL_LOOP  = 5'd17,
        SEL_LOOPZ = 5'd18,
        SEL_LOOPN = 5'd19
    } cond_e;
endpackage

// File: rtl/bce_flag_test.sv
module bce_flag_test
    import bce_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  flags_t           flags,
    output logic             hit
);
    logic s_ne_o;

    always_comb begin
        s_ne_o = flags.s ^ flags.o;
        case (cond_e'(sel))
            SEL_CSET: hit = flags.c;
            SEL_CCLR: hit = !flags.c;
            SEL_ZSET: hit = flags.z;
            SEL_ZCLR: hit = !flags.z;
            SEL_BE:   hit = flags.c | flags.z;
            SEL_A:    hit = !(flags.c | flags.z);
            SEL_SSET: hit = flags.s;
            SEL_SCLR: hit = !flags.s;
            SEL_PSET: hit = flags.p;
            SEL_PCLR: hit = !flags.p;
            SEL_LT:   hit = s_ne_o;
            SEL_GE:   hit = !s_ne_o;
            SEL_LE:   hit = flags.z | s_ne_o;
            SEL_GT:   hit = !(flags.z | s_ne_o);
            SEL_OSET: hit = flags.o;
            SEL_OCLR: hit = !flags.o;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bce_count_unit.sv
module bce_count_unit
    import bce_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic             zf,
    input  logic [CNT_W-1:0] cnt,
    output logic             hit,
    output logic             wr,
    output logic [CNT_W-1:0] cnt_new
);
    logic [CNT_W-1:0] dec;
    logic             dec_nz;

    always_comb begin
        dec     = cnt - CNT_W'(1);
        dec_nz  = |dec;
        hit     = 1'b0;
        wr      = 1'b0;
        cnt_new = cnt;
        case (cond_e'(sel))
            SEL_CNTZ:  hit = ~|cnt;
            SEL_LOOP:  begin wr = 1'b1; cnt_new = dec; hit = dec_nz;        end
            SEL_LOOPZ: begin wr = 1'b1; cnt_new = dec; hit = dec_nz & zf;   end
            SEL_LOOPN: begin wr = 1'b1; cnt_new = dec; hit = dec_nz & !zf;  end
            default:   ;
        endcase
    end
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import bce_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SEL_W-1:0] cond_sel,
    input  logic             flag_c,
    input  logic             flag_z,
    input  logic             flag_s,
    input  logic             flag_o,
    input  logic             flag_p,
    input  logic [CNT_W-1:0] count_in,
    output logic             out_valid,
    output logic             taken,
    output logic             cnt_wr,
    output logic [CNT_W-1:0] cnt_out
);
    localparam logic [SEL_W-1:0] FIRST_RSVD = SEL_W'(20);

    typedef struct packed {
        logic             valid;
        logic             taken;
        logic             wr;
        logic [CNT_W-1:0] cnt;
    } res_t;

    flags_t           flags;
    logic             flag_hit;
    logic             cnt_hit;
    logic             cnt_wr_c;
    logic [CNT_W-1:0] cnt_new;
    res_t             res_d, res_q;

    assign flags = '{c: flag_c, z: flag_z, s: flag_s, o: flag_o, p: flag_p};

    bce_flag_test u_flag (
        .sel   (cond_sel),
        .flags (flags),
        .hit   (flag_hit)
    );

    bce_count_unit #(.CNT_W(CNT_W)) u_cnt (
        .sel     (cond_sel),
        .zf      (flag_z),
        .cnt     (count_in),
        .hit     (cnt_hit),
        .wr      (cnt_wr_c),
        .cnt_new (cnt_new)
    );

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid = 1'b1;
            res_d.taken = flag_hit | cnt_hit;
            res_d.wr    = cnt_wr_c;
            res_d.cnt   = cnt_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign taken     = res_q.taken;
    assign cnt_wr    = res_q.wr;
    assign cnt_out   = res_q.cnt;

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!taken && !cnt_wr && !out_valid));

    a_r6_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |-> (cnt_out == CNT_W'($past(count_in) - CNT_W'(1))));

    a_r5_cntz_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && cond_sel == SEL_W'(16)) |->
            (!cnt_wr && (taken == ($past(count_in) == '0))));

    a_r9_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && cond_sel >= FIRST_RSVD) |-> (!taken && !cnt_wr));

    a_r6_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && taken) |-> (cnt_out != '0));
endmodule

// File: tb/tb_branch_cond_eval.sv
module tb_branch_cond_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [4:0]  cond_sel = '0;
    logic        flag_c = 0, flag_z = 0, flag_s = 0, flag_o = 0, flag_p = 0;
    logic [15:0] count_in = '0;
    logic        out_valid, taken, cnt_wr;
    logic [15:0] cnt_out;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    branch_cond_eval dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_sel(cond_sel),
        .flag_c(flag_c), .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o),
        .flag_p(flag_p), .count_in(count_in), .out_valid(out_valid),
        .taken(taken), .cnt_wr(cnt_wr), .cnt_out(cnt_out)
    );

    // {sel[4:0], flags{c,z,s,o,p}, count[15:0], exp_taken, exp_wr}
    localparam int NV = 38;
    localparam logic [27:0] VEC [NV] = '{
        {5'd0,  5'b10000, 16'd0, 1'b1, 1'b0},   // R2
        {5'd0,  5'b00000, 16'd0, 1'b0, 1'b0},   // R2
        {5'd1,  5'b00000, 16'd0, 1'b1, 1'b0},   // R2
        {5'd1,  5'b10000, 16'd0, 1'b0, 1'b0},   // R2
        {5'd2,  5'b01000, 16'd0, 1'b1, 1'b0},   // R2
        {5'd3,  5'b01000, 16'd0, 1'b0, 1'b0},   // R2
        {5'd6,  5'b00100, 16'd0, 1'b1, 1'b0},   // R2
        {5'd7,  5'b00100, 16'd0, 1'b0, 1'b0},   // R2
        {5'd8,  5'b00001, 16'd0, 1'b1, 1'b0},   // R2
        {5'd9,  5'b00001, 16'd0, 1'b0, 1'b0},   // R2
        {5'd14, 5'b00010, 16'd0, 1'b1, 1'b0},   // R2
        {5'd15, 5'b00010, 16'd0, 1'b0, 1'b0},   // R2
        {5'd4,  5'b01000, 16'd0, 1'b1, 1'b0},   // R3
        {5'd4,  5'b00000, 16'd0, 1'b0, 1'b0},   // R3
        {5'd4,  5'b10000, 16'd0, 1'b1, 1'b0},   // R3
        {5'd5,  5'b00000, 16'd0, 1'b1, 1'b0},   // R3
        {5'd5,  5'b10000, 16'd0, 1'b0, 1'b0},   // R3
        {5'd5,  5'b01000, 16'd0, 1'b0, 1'b0},   // R3
        {5'd10, 5'b00100, 16'd0, 1'b1, 1'b0},   // R4
        {5'd10, 5'b00110, 16'd0, 1'b0, 1'b0},   // R4
        {5'd11, 5'b00110, 16'd0, 1'b1, 1'b0},   // R4
        {5'd11, 5'b00010, 16'd0, 1'b0, 1'b0},   // R4
        {5'd12, 5'b01110, 16'd0, 1'b1, 1'b0},   // R4
        {5'd12, 5'b00000, 16'd0, 1'b0, 1'b0},   // R4
        {5'd13, 5'b00000, 16'd0, 1'b1, 1'b0},   // R4
        {5'd13, 5'b00010, 16'd0, 1'b0, 1'b0},   // R4
        {5'd16, 5'b00000, 16'd0, 1'b1, 1'b0},   // R5
        {5'd16, 5'b11111, 16'd5, 1'b0, 1'b0},   // R5
        {5'd17, 5'b00000, 16'd1, 1'b0, 1'b1},   // R6
        {5'd17, 5'b00000, 16'd0, 1'b1, 1'b1},   // R6
        {5'd17, 5'b01000, 16'd3, 1'b1, 1'b1},   // R6
        {5'd18, 5'b01000, 16'd3, 1'b1, 1'b1},   // R7
        {5'd18, 5'b00000, 16'd3, 1'b0, 1'b1},   // R7
        {5'd18, 5'b01000, 16'd1, 1'b0, 1'b1},   // R7
        {5'd19, 5'b00000, 16'd3, 1'b1, 1'b1},   // R8
        {5'd19, 5'b01000, 16'd3, 1'b0, 1'b1},   // R8
        {5'd20, 5'b11111, 16'd0, 1'b0, 1'b0},   // R9
        {5'd31, 5'b11111, 16'd7, 1'b0, 1'b0}    // R9
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [27:0] w);
        in_valid = v;
        cond_sel = w[27:23];
        {flag_c, flag_z, flag_s, flag_o, flag_p} = w[22:18];
        count_in = w[17:2];
    endtask

    task automatic check_vec(input logic [27:0] w, input string req);
        logic [15:0] ec;
        ec = w[0] ? (w[17:2] - 16'd1) : w[17:2];
        chk({req, " out_valid"}, 16'(out_valid), 16'd1);
        chk({req, " taken"},     16'(taken),     16'(w[1]));
        chk({req, " cnt_wr"},    16'(cnt_wr),    16'(w[0]));
        chk({req, " cnt_out"},   cnt_out,        ec);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 taken", 16'(taken), 16'd0);
        chk("R1 cnt_wr", 16'(cnt_wr), 16'd0);
        chk("R1 out_valid", 16'(out_valid), 16'd0);
        chk("R1 cnt_out", cnt_out, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {13'd0, out_valid, taken, cnt_wr}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VEC[i]);
            @(negedge clk);
            check_vec(VEC[i], $sformatf("vec%0d sel%0d", i, VEC[i][27:23]));
        end

        // R10: idle cycle with a condition that would be taken and would write
        drive(1'b0, {5'd17, 5'b00000, 16'd9, 2'b00});
        @(negedge clk);
        chk("R10 taken", 16'(taken), 16'd0);
        chk("R10 cnt_wr", 16'(cnt_wr), 16'd0);
        chk("R10 out_valid", 16'(out_valid), 16'd0);

        // R11: back-to-back, one-cycle latency
        drive(1'b1, {5'd16, 5'b00000, 16'd0, 2'b00});
        @(posedge clk); #1;
        chk("R11 first result after edge", 16'(taken), 16'd1);
        drive(1'b1, {5'd17, 5'b00000, 16'd1, 2'b00});
        @(negedge clk);
        chk("R11 first still held", 16'(taken), 16'd1);
        chk("R11 first no write", 16'(cnt_wr), 16'd0);
        @(posedge clk); #1;
        chk("R11 second taken", 16'(taken), 16'd0);
        chk("R11 second write", 16'(cnt_wr), 16'd1);
        chk("R11 second count", cnt_out, 16'd0);
        drive(1'b0, '0);

        // R6: large count wrap boundary
        @(negedge clk);
        drive(1'b1, {5'd17, 5'b00000, 16'hFFFF, 2'b00});
        @(negedge clk);
        chk("R6 FFFF dec", cnt_out, 16'hFFFE);
        chk("R6 FFFF taken", 16'(taken), 16'd1);

        // R1: reset in mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset", {13'd0, out_valid, taken, cnt_wr}, 16'd0);
        chk("R1 mid-run count", cnt_out, 16'd0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule